// File: doc/BRIEF.md
# Hardware Repeat Loop Controller

This block sits next to a processor's fetch unit and runs counted loops with no branch instruction at the loop end. Three write ports stand in for the three setup instructions: one loads the loop-start pointer, one loads the loop-end pointer, and one writes the 12-bit iteration count. The count write also snapshots the signed difference between the two pointers (end minus start), which fixes the loop length, and derives the addresses the block watches for.

For every completed instruction the core reports its address and whether it branched. The block arms itself when the instruction just before the loop body completes normally while the count is non-zero. Each time the last loop instruction then completes, it either asks fetch to restart at the loop's first instruction, decrementing the count, or lets execution run on past the loop. The live count is brought out so that the status register can mirror it. Instructions are 2 bytes long.

For loops of one to three instructions the two pointers do not mark the loop bounds. Both are placed relative to the first loop instruction S: the end pointer holds S+4 and the start pointer holds S+10-2N, N being the number of loop instructions. A difference that is neither positive nor one of the three short-loop values raises an error flag.

Top module: `rpt_loop_ctrl`

## Requirements
- R1: A count write loads `cnt_wdata` into the 12-bit counter, shown on `rep_count` after the next rising edge. Pointer writes leave the counter and the other outputs unchanged.
- R2: At a count write, end pointer minus start pointer (signed, in bytes) sets the loop length: any positive value is a long loop, 0 is three instructions, -2 is two, -4 is one.
- R3: Watched addresses, taken at the count write: for a short loop the first instruction is S = end pointer - 4, the last is S + 2*(N-1) and the arming instruction is S - 2. For a long loop the first is the start pointer, the last is the end pointer and the arming instruction is start pointer - 2.
- R4: A zero or negative difference other than 0, -2 or -4 sets `loop_err` after the count write, and no loop is recognised. The next count write with a valid difference clears it.
- R5: The loop arms only when the arming instruction completes with `ret_branch` low while the counter is non-zero. With a zero count, completing the last loop instruction causes no redirect.
- R6: While armed, the last loop instruction completing without a branch with the counter at 2 or more gives `redirect_valid` high for one cycle after that edge, `redirect_addr` equal to the first loop instruction, and the counter one lower.
- R7: While armed, the last loop instruction completing with the counter at 1 clears the counter to 0, gives no redirect and disarms, so later passes run straight through.
- R8: Any completed instruction with `ret_branch` high disarms the loop and causes no redirect. Only a later normal completion of the arming instruction re-arms it.
- R9: Synchronous reset clears both pointers, the counter, the loop length, the error flag and the redirect output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_wr | input | 1 | Load the loop-start pointer |
| rs_wdata | input | ADDR_W | Value for the loop-start pointer |
| re_wr | input | 1 | Load the loop-end pointer |
| re_wdata | input | ADDR_W | Value for the loop-end pointer |
| cnt_wr | input | 1 | Write the count and classify the loop |
| cnt_wdata | input | CNT_W | Iteration count |
| ret_valid | input | 1 | An instruction completed this cycle |
| ret_addr | input | ADDR_W | Address of the completed instruction |
| ret_branch | input | 1 | The completed instruction branched |
| redirect_valid | output | 1 | Restart fetch at `redirect_addr` |
| redirect_addr | output | ADDR_W | First loop instruction |
| rep_count | output | CNT_W | Current iteration count |
| loop_err | output | 1 | Unsupported pointer difference seen at the last count write |

## Verification
The assertions assume that a count write and an instruction completion never occur in the same cycle. They also assume that the pointers are written before the count write that uses them, and that completion addresses are even. Under those conditions the armed state can only come from a normal completion at a non-zero count, and each redirect lowers the count by exactly one. The stimulus issues one operation per cycle, with setup always ahead of the loop body. It covers each loop length, the branch cases, a zero count, the largest count and two unsupported differences.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [2:0] {
    LK_NONE  = 3'd0,
    LK_ONE   = 3'd1,
    LK_TWO   = 3'd2,
    LK_THREE = 3'd3,
    LK_LONG  = 3'd4
  } loop_kind_e;
endpackage

// File: rtl/rpt_classify.sv
module rpt_classify
  import rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IBYTES = 2
) (
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [ADDR_W-1:0] end_ptr,
  output loop_kind_e        kind,
  output logic              bad
);
  localparam logic signed [ADDR_W-1:0] STEP = ADDR_W'(IBYTES);

  logic signed [ADDR_W-1:0] diff;

  always_comb begin
    diff = $signed(end_ptr - start_ptr);
    bad  = 1'b0;
    if (diff > 0)                 kind = LK_LONG;
    else if (diff == '0)          kind = LK_THREE;
    else if (diff == -STEP)       kind = LK_TWO;
    else if (diff == -(STEP * 2)) kind = LK_ONE;
    else begin
      kind = LK_NONE;
      bad  = 1'b1;
    end
  end
endmodule

// File: rtl/rpt_bounds.sv
module rpt_bounds
  import rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IBYTES = 2
) (
  input  loop_kind_e        kind,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [ADDR_W-1:0] end_ptr,
  output logic [ADDR_W-1:0] det_addr,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] last_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(IBYTES);

  logic [ADDR_W-1:0] short_first;

  always_comb begin
    short_first = end_ptr - (STEP << 1);
    case (kind)
      LK_ONE: begin
        first_addr = short_first;
        last_addr  = short_first;
      end
      LK_TWO: begin
        first_addr = short_first;
        last_addr  = short_first + STEP;
      end
      LK_THREE: begin
        first_addr = short_first;
        last_addr  = short_first + (STEP << 1);
      end
      default: begin
        first_addr = start_ptr;
        last_addr  = end_ptr;
      end
    endcase
    det_addr = first_addr - STEP;
  end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              loop_ok,
  input  logic [ADDR_W-1:0] det_addr,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              ret_branch,
  output logic [CNT_W-1:0]  count,
  output logic              armed,
  output logic              redir_v,
  output logic [ADDR_W-1:0] redir_a
);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      armed   <= 1'b0;
      redir_v <= 1'b0;
      redir_a <= '0;
    end else begin
      redir_v <= 1'b0;
      if (load) begin
        count <= load_val;
        armed <= 1'b0;
      end else if (ret_valid) begin
        if (ret_branch) begin
          armed <= 1'b0;
        end else if (armed && ret_addr == last_addr) begin
          if (count >= TWO) begin
            count   <= count - 1'b1;
            redir_v <= 1'b1;
            redir_a <= first_addr;
          end else begin
            count <= '0;
            armed <= 1'b0;
          end
        end else if (!armed && loop_ok && ret_addr == det_addr && count != '0) begin
          armed <= 1'b1;
        end
      end
    end
  end

  assert_redirect_dec_R6: assert property (@(posedge clk) disable iff (rst)
    redir_v |-> (count == CNT_W'($past(count) - 1'b1)));

  assert_redirect_min_R6: assert property (@(posedge clk) disable iff (rst)
    redir_v |-> ($past(count) >= TWO));

  assert_arm_needs_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(count) != '0 && $past(ret_valid) && !$past(ret_branch)));

  assert_branch_disarm_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_branch && !load) |=> (!armed && !redir_v));
endmodule

// File: rtl/rpt_loop_ctrl.sv
module rpt_loop_ctrl
  import rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int IBYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_wr,
  input  logic [ADDR_W-1:0] rs_wdata,
  input  logic              re_wr,
  input  logic [ADDR_W-1:0] re_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              ret_branch,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic [CNT_W-1:0]  rep_count,
  output logic              loop_err
);
  logic [ADDR_W-1:0] rs_q, re_q;
  logic [ADDR_W-1:0] det_q, first_q, last_q;
  logic [ADDR_W-1:0] det_c, first_c, last_c;
  loop_kind_e        kind_q, kind_c;
  logic              bad_c;
  logic              armed;

  rpt_classify #(.ADDR_W(ADDR_W), .IBYTES(IBYTES)) u_classify (
    .start_ptr (rs_q),
    .end_ptr   (re_q),
    .kind      (kind_c),
    .bad       (bad_c)
  );

  rpt_bounds #(.ADDR_W(ADDR_W), .IBYTES(IBYTES)) u_bounds (
    .kind       (kind_c),
    .start_ptr  (rs_q),
    .end_ptr    (re_q),
    .det_addr   (det_c),
    .first_addr (first_c),
    .last_addr  (last_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q     <= '0;
      re_q     <= '0;
      kind_q   <= LK_NONE;
      loop_err <= 1'b0;
      det_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      if (rs_wr) rs_q <= rs_wdata;
      if (re_wr) re_q <= re_wdata;
      if (cnt_wr) begin
        kind_q   <= kind_c;
        loop_err <= bad_c;
        det_q    <= det_c;
        first_q  <= first_c;
        last_q   <= last_c;
      end
    end
  end

  rpt_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (cnt_wr),
    .load_val   (cnt_wdata),
    .loop_ok    (kind_q != LK_NONE),
    .det_addr   (det_q),
    .first_addr (first_q),
    .last_addr  (last_q),
    .ret_valid  (ret_valid),
    .ret_addr   (ret_addr),
    .ret_branch (ret_branch),
    .count      (rep_count),
    .armed      (armed),
    .redir_v    (redirect_valid),
    .redir_a    (redirect_addr)
  );

  assert_err_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    loop_err |-> (!armed && !redirect_valid));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !ret_valid) |=> $stable(rep_count));

  assert_redirect_cause_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> ($past(ret_valid) && !$past(ret_branch) && !$past(cnt_wr)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (rep_count == '0 && !loop_err && !redirect_valid));
endmodule

// File: tb/test_rpt_loop_ctrl.sv
module test_rpt_loop_ctrl;
  localparam int AW = 32;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rs_wr = 1'b0, re_wr = 1'b0, cnt_wr = 1'b0;
  logic [AW-1:0] rs_wdata = '0, re_wdata = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic          ret_valid = 1'b0, ret_branch = 1'b0;
  logic [AW-1:0] ret_addr = '0;
  logic          redirect_valid;
  logic [AW-1:0] redirect_addr;
  logic [CW-1:0] rep_count;
  logic          loop_err;

  always #10ns clk = ~clk;

  rpt_loop_ctrl #(.ADDR_W(AW), .CNT_W(CW), .IBYTES(2)) i_rpt_loop_ctrl (
    .clk(clk), .rst(rst),
    .rs_wr(rs_wr), .rs_wdata(rs_wdata),
    .re_wr(re_wr), .re_wdata(re_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_branch(ret_branch),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .rep_count(rep_count), .loop_err(loop_err)
  );

  typedef struct {
    bit            rv;
    logic [AW-1:0] ra;
    logic [CW-1:0] cnt;
    bit            err;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [CW-1:0] cnt_e = '0;
  bit err_e = 0;

  // Monitor: compares one expected item per clock, just after the edge
  always @(posedge clk) begin
    if (!rst) begin
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (redirect_valid !== e.rv || (e.rv && redirect_addr !== e.ra)) begin
          failures++;
          $display("FAIL %s redirect: got v=%0b a=%h expected v=%0b a=%h",
                   e.tag, redirect_valid, redirect_addr, e.rv, e.ra);
        end
        checks++;
        if (rep_count !== e.cnt) begin
          failures++;
          $display("FAIL %s count: got %0d expected %0d", e.tag, rep_count, e.cnt);
        end
        checks++;
        if (loop_err !== e.err) begin
          failures++;
          $display("FAIL %s error flag: got %0b expected %0b", e.tag, loop_err, e.err);
        end
      end
    end
  end

  task automatic clear_inputs();
    rs_wr = 0; re_wr = 0; cnt_wr = 0; ret_valid = 0; ret_branch = 0;
  endtask

  task automatic push(string tag, bit rv, logic [AW-1:0] ra);
    exp_t e;
    e.rv = rv; e.ra = ra; e.cnt = cnt_e; e.err = err_e; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic load_ptrs(logic [AW-1:0] s, logic [AW-1:0] en);
    @(negedge clk); clear_inputs(); rs_wr = 1; rs_wdata = s;
    push("R1", 0, '0);
    @(negedge clk); clear_inputs(); re_wr = 1; re_wdata = en;
    push("R1", 0, '0);
  endtask

  task automatic set_count(string tag, logic [CW-1:0] c, bit bad);
    @(negedge clk); clear_inputs(); cnt_wr = 1; cnt_wdata = c;
    cnt_e = c; err_e = bad;
    push(tag, 0, '0);
  endtask

  task automatic retire(string tag, logic [AW-1:0] a, bit br, bit rv,
                        logic [AW-1:0] ra, logic [CW-1:0] newcnt);
    @(negedge clk); clear_inputs(); ret_valid = 1; ret_addr = a; ret_branch = br;
    cnt_e = newcnt;
    push(tag, rv, ra);
  endtask

  initial begin
    #2000000ns;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: reset state
    @(negedge clk); clear_inputs(); push("R9", 0, '0);

    // One-instruction loop, first instruction 0x100 (R2, R3, R5, R6, R7)
    load_ptrs(32'h108, 32'h104);
    set_count("R1", 12'd3, 0);
    retire("R5", 32'h0FC, 0, 0, '0, 12'd3);
    retire("R5", 32'h0FE, 0, 0, '0, 12'd3);
    retire("R6", 32'h100, 0, 1, 32'h100, 12'd2);
    retire("R6", 32'h100, 0, 1, 32'h100, 12'd1);
    retire("R7", 32'h100, 0, 0, '0, 12'd0);
    retire("R7", 32'h100, 0, 0, '0, 12'd0);

    // Two-instruction loop at 0x200 (R2, R3)
    load_ptrs(32'h206, 32'h204);
    set_count("R2", 12'd2, 0);
    retire("R3", 32'h1FE, 0, 0, '0, 12'd2);
    retire("R3", 32'h200, 0, 0, '0, 12'd2);
    retire("R3", 32'h202, 0, 1, 32'h200, 12'd1);
    retire("R3", 32'h200, 0, 0, '0, 12'd1);
    retire("R7", 32'h202, 0, 0, '0, 12'd0);

    // Three-instruction loop at 0x300 with branches (R8)
    load_ptrs(32'h304, 32'h304);
    set_count("R2", 12'd5, 0);
    retire("R8", 32'h2FE, 1, 0, '0, 12'd5);
    retire("R8", 32'h300, 0, 0, '0, 12'd5);
    retire("R8", 32'h302, 0, 0, '0, 12'd5);
    retire("R8", 32'h304, 0, 0, '0, 12'd5);
    retire("R5", 32'h2FE, 0, 0, '0, 12'd5);
    retire("R3", 32'h300, 0, 0, '0, 12'd5);
    retire("R3", 32'h302, 0, 0, '0, 12'd5);
    retire("R6", 32'h304, 0, 1, 32'h300, 12'd4);
    retire("R8", 32'h300, 0, 0, '0, 12'd4);
    retire("R8", 32'h302, 1, 0, '0, 12'd4);
    retire("R8", 32'h304, 0, 0, '0, 12'd4);

    // Long loop 0x400..0x40A (R2, R3)
    load_ptrs(32'h400, 32'h40A);
    set_count("R2", 12'd2, 0);
    retire("R5", 32'h3FE, 0, 0, '0, 12'd2);
    retire("R3", 32'h404, 0, 0, '0, 12'd2);
    retire("R6", 32'h40A, 0, 1, 32'h400, 12'd1);
    retire("R7", 32'h40A, 0, 0, '0, 12'd0);

    // Zero count never arms (R5)
    set_count("R5", 12'd0, 0);
    retire("R5", 32'h3FE, 0, 0, '0, 12'd0);
    retire("R5", 32'h40A, 0, 0, '0, 12'd0);

    // Unsupported differences -6 and -1 (R4)
    load_ptrs(32'h500, 32'h4FA);
    set_count("R4", 12'd3, 1);
    retire("R4", 32'h4F4, 0, 0, '0, 12'd3);
    retire("R4", 32'h4F6, 0, 0, '0, 12'd3);
    retire("R4", 32'h4F8, 0, 0, '0, 12'd3);
    retire("R4", 32'h4FA, 0, 0, '0, 12'd3);
    load_ptrs(32'h501, 32'h500);
    set_count("R4", 12'd2, 1);
    retire("R4", 32'h4FE, 0, 0, '0, 12'd2);
    retire("R4", 32'h500, 0, 0, '0, 12'd2);

    // Recovery with a valid three-instruction loop at 0x600, count 1 (R4, R7)
    load_ptrs(32'h604, 32'h604);
    set_count("R4", 12'd1, 0);
    retire("R5", 32'h5FE, 0, 0, '0, 12'd1);
    retire("R7", 32'h600, 0, 0, '0, 12'd1);
    retire("R7", 32'h602, 0, 0, '0, 12'd1);
    retire("R7", 32'h604, 0, 0, '0, 12'd0);

    // Largest count on a short long-loop 0x700..0x702 (R1, R6)
    load_ptrs(32'h700, 32'h702);
    set_count("R1", 12'd4095, 0);
    retire("R5", 32'h6FE, 0, 0, '0, 12'd4095);
    retire("R6", 32'h700, 0, 0, '0, 12'd4095);
    retire("R6", 32'h702, 0, 1, 32'h700, 12'd4094);

    @(negedge clk); clear_inputs(); push("R1", 0, '0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule